// File: doc/BRIEF.md
# Nested Interrupt Entry and Exit Sequencer

This block sits beside a processor core and decides when the core must leave its current work to service an interrupt. It watches a parameterised set of request lines, each with its own enable bit and a two-bit urgency value where a smaller number is more urgent. It then steps through entry and exit phases: a context save of fixed length, a one-cycle vector-table fetch with a handler-start pulse, the handler run, and a context restore of fixed length. The save and restore phases stand in for the real stack traffic, and a busy flag covers them.

Handlers nest. A strictly more urgent request preempts the running handler and starts a fresh save. When a handler finishes while another eligible request waits, the sequencer chains straight to the next vector fetch and skips both the restore and the save. A more urgent request that arrives while a save is in progress takes over the fetch that ends that save. The request it displaces stays pending. A small stack of active handlers keeps track of which handler and urgency level resume after a nested one returns.

Top module: `irq_nest_seq`

## Requirements
- R1: After reset, `phase` is 0 (idle), `busy`, `hdl_start` and `act_valid` are 0. Phase codes: 0 idle, 1 save, 2 vector fetch, 3 handler run, 4 restore.
- R2: A line becomes pending on a rising edge of its request input, whether it is enabled or not. A disabled pending line is never selected, and it is serviced once it is enabled. Pending is cleared when that line's vector is fetched.
- R3: Among pending enabled lines, the smallest urgency value is chosen. On a tie, the lowest line number wins.
- R4: Entry from idle or by preemption is a save phase lasting `STACK_CYCLES` cycles with `busy` high, then one fetch cycle with `hdl_start` high, then the run phase.
- R5: During the fetch cycle `vec_addr` equals `tbl_base + 4*(EXC_OFFSET + line)`.
- R6: A pending request whose urgency value is strictly smaller than that of the running handler preempts it, and it becomes the active line.
- R7: A request whose urgency value is equal to or larger than that of the running handler does not leave the run phase until `hdl_done`.
- R8: On `hdl_done`, if a request is eligible against the level that would resume, the next cycle is a fetch phase, with no restore or save in between.
- R9: A request more urgent than the one being saved replaces it for the fetch that ends the save. The save is not restarted, and the displaced line is serviced afterwards.
- R10: On `hdl_done` with nothing eligible, a restore phase of `STACK_CYCLES` busy cycles follows. It returns to the run phase of the preempted handler, with its line shown on `act_id`, or to idle when no handler remains.
- R11: The nesting depth never exceeds `NUM_LINES`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NUM_LINES | Request lines, rising edge marks pending |
| irq_en | input | NUM_LINES | Per-line enable |
| irq_prio | input | NUM_LINES*PRIO_W | Urgency per line, line i at bits i*PRIO_W, smaller is more urgent |
| tbl_base | input | 32 | Vector table base address |
| hdl_done | input | 1 | Handler-finished strobe from the core |
| phase | output | 3 | Current phase code |
| busy | output | 1 | High during save and restore |
| hdl_start | output | 1 | One-cycle pulse in the fetch cycle |
| vec_addr | output | 32 | Vector entry address, valid in the fetch cycle |
| act_valid | output | 1 | A handler is active |
| act_id | output | ID_W | Line number of the active handler |

## Verification
A corrupted pending bit or a wrong arbitration shows up at the next fetch: `vec_addr` carries a different line than the scoreboard queue expects, or a fetch appears where none was queued. A stale nesting entry stays hidden until the handler above it returns. Then the restore lands in idle or in the wrong line, or a tail chain is taken or refused wrongly, and this is visible in `phase` the cycle after `hdl_done`. An off-by-one save or restore counter is caught the first time `busy` falls, because the length of every busy run is measured.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_SAVE  = 3'd1,
      PH_FETCH = 3'd2,
      PH_RUN   = 3'd3,
      PH_REST  = 3'd4
   } seq_phase_e;

   function automatic int unsigned id_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int unsigned NUM_LINES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] req_i,
   input  logic [NUM_LINES-1:0] clr_i,
   output logic [NUM_LINES-1:0] pend_o
);

   logic [NUM_LINES-1:0] prev_q;

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q[g] <= 1'b0;
            pend_o[g] <= 1'b0;
         end else begin
            prev_q[g] <= req_i[g];
            // a fresh edge wins over a clear in the same cycle
            pend_o[g] <= (pend_o[g] & ~clr_i[g]) | (req_i[g] & ~prev_q[g]);
         end
      end

      p_edge_sets_pend_r2 : assert property (@(posedge clk) disable iff (!rst_n)
         $rose(req_i[g]) |=> pend_o[g]);
   end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned PRIO_W    = 2,
   localparam int unsigned ID_W     = irq_seq_pkg::id_width(NUM_LINES)
) (
   input  logic [NUM_LINES-1:0]        pend_i,
   input  logic [NUM_LINES-1:0]        en_i,
   input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
   output logic                        valid_o,
   output logic [ID_W-1:0]             id_o,
   output logic [PRIO_W-1:0]           prio_o
);

   logic [NUM_LINES-1:0] cand;
   assign cand = pend_i & en_i;

   always_comb begin
      valid_o = 1'b0;
      id_o    = '0;
      prio_o  = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         // strict compare keeps the lower line number on a tie
         if (cand[i] && (!valid_o || prio_i[i*PRIO_W +: PRIO_W] < prio_o)) begin
            valid_o = 1'b1;
            id_o    = ID_W'(i);
            prio_o  = prio_i[i*PRIO_W +: PRIO_W];
         end
      end
   end

endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned ID_W   = 3,
   parameter int unsigned PRIO_W = 2,
   localparam int unsigned DW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic [ID_W-1:0]   push_id_i,
   input  logic [PRIO_W-1:0] push_prio_i,
   output logic [DW-1:0]     depth_o,
   output logic [ID_W-1:0]   top_id_o,
   output logic [PRIO_W-1:0] top_prio_o,
   output logic [PRIO_W-1:0] below_prio_o
);

   logic [ID_W-1:0]   id_mem   [DEPTH];
   logic [PRIO_W-1:0] prio_mem [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            id_mem[g]   <= '0;
            prio_mem[g] <= '0;
         end else if (push_i && depth_o == DW'(g)) begin
            id_mem[g]   <= push_id_i;
            prio_mem[g] <= push_prio_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         depth_o <= '0;
      else if (push_i)
         depth_o <= depth_o + DW'(1);
      else if (pop_i)
         depth_o <= depth_o - DW'(1);
   end

   always_comb begin
      top_id_o     = '0;
      top_prio_o   = '0;
      below_prio_o = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (DW'(i + 1) == depth_o) begin
            top_id_o   = id_mem[i];
            top_prio_o = prio_mem[i];
         end
         if (DW'(i + 2) == depth_o)
            below_prio_o = prio_mem[i];
      end
   end

   p_no_overflow_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> depth_o < DW'(DEPTH));

   p_no_underflow_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> depth_o != '0);

   p_single_op_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      !(push_i && pop_i));

endmodule

// File: rtl/irq_nest_seq.sv
module irq_nest_seq
   import irq_seq_pkg::*;
#(
   parameter int unsigned NUM_LINES    = 8,
   parameter int unsigned PRIO_W       = 2,
   parameter int unsigned STACK_CYCLES = 8,
   parameter int unsigned EXC_OFFSET   = 16,
   localparam int unsigned ID_W        = id_width(NUM_LINES),
   localparam int unsigned CW          = (STACK_CYCLES > 1) ? $clog2(STACK_CYCLES) : 1,
   localparam int unsigned DW          = $clog2(NUM_LINES + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_LINES-1:0]        irq_req,
   input  logic [NUM_LINES-1:0]        irq_en,
   input  logic [NUM_LINES*PRIO_W-1:0] irq_prio,
   input  logic [31:0]                 tbl_base,
   input  logic                        hdl_done,
   output logic [2:0]                  phase,
   output logic                        busy,
   output logic                        hdl_start,
   output logic [31:0]                 vec_addr,
   output logic                        act_valid,
   output logic [ID_W-1:0]             act_id
);

   if (NUM_LINES < 2 || NUM_LINES > 64) begin : g_bad_lines
      $error("irq_nest_seq: NUM_LINES must lie in 2..64");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("irq_nest_seq: PRIO_W must lie in 1..8");
   end
   if (STACK_CYCLES < 1) begin : g_bad_stack
      $error("irq_nest_seq: STACK_CYCLES must be at least 1");
   end

   localparam logic [CW-1:0] CNT_LAST = CW'(STACK_CYCLES - 1);

   seq_phase_e           state_q;
   logic [CW-1:0]        cnt_q;
   logic [ID_W-1:0]      tgt_id_q;
   logic [PRIO_W-1:0]    tgt_prio_q;

   logic [NUM_LINES-1:0] pend_vec;
   logic [NUM_LINES-1:0] clr_vec;
   logic                 sel_valid;
   logic [ID_W-1:0]      sel_id;
   logic [PRIO_W-1:0]    sel_prio;

   logic [DW-1:0]        depth;
   logic [ID_W-1:0]      top_id;
   logic [PRIO_W-1:0]    top_prio;
   logic [PRIO_W-1:0]    below_prio;
   logic                 stk_push;
   logic                 stk_pop;

   logic                 preempt;
   logic                 chain_ok;
   logic                 late_swap;
   logic [31:0]          exc_num;

   irq_pend_bank #(.NUM_LINES(NUM_LINES)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (irq_req),
      .clr_i  (clr_vec),
      .pend_o (pend_vec)
   );

   irq_pick #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_pick (
      .pend_i  (pend_vec),
      .en_i    (irq_en),
      .prio_i  (irq_prio),
      .valid_o (sel_valid),
      .id_o    (sel_id),
      .prio_o  (sel_prio)
   );

   irq_nest_stack #(.DEPTH(NUM_LINES), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_stack (
      .clk          (clk),
      .rst_n        (rst_n),
      .push_i       (stk_push),
      .pop_i        (stk_pop),
      .push_id_i    (tgt_id_q),
      .push_prio_i  (tgt_prio_q),
      .depth_o      (depth),
      .top_id_o     (top_id),
      .top_prio_o   (top_prio),
      .below_prio_o (below_prio)
   );

   assign stk_push  = (state_q == PH_FETCH);
   assign stk_pop   = (state_q == PH_RUN) && hdl_done;
   assign clr_vec   = stk_push ? (NUM_LINES'(1) << tgt_id_q) : '0;

   assign preempt   = sel_valid && (depth == '0 || sel_prio < top_prio);
   assign chain_ok  = sel_valid && (depth < DW'(2) || sel_prio < below_prio);
   assign late_swap = sel_valid && (sel_prio < tgt_prio_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= PH_IDLE;
         cnt_q      <= '0;
         tgt_id_q   <= '0;
         tgt_prio_q <= '0;
      end else begin
         unique case (state_q)
            PH_IDLE: begin
               if (sel_valid) begin
                  state_q    <= PH_SAVE;
                  cnt_q      <= CNT_LAST;
                  tgt_id_q   <= sel_id;
                  tgt_prio_q <= sel_prio;
               end
            end
            PH_SAVE: begin
               if (late_swap) begin
                  tgt_id_q   <= sel_id;
                  tgt_prio_q <= sel_prio;
               end
               if (cnt_q == '0)
                  state_q <= PH_FETCH;
               else
                  cnt_q <= cnt_q - CW'(1);
            end
            PH_FETCH: begin
               state_q <= PH_RUN;
            end
            PH_RUN: begin
               if (hdl_done) begin
                  if (chain_ok) begin
                     state_q    <= PH_FETCH;
                     tgt_id_q   <= sel_id;
                     tgt_prio_q <= sel_prio;
                  end else begin
                     state_q <= PH_REST;
                     cnt_q   <= CNT_LAST;
                  end
               end else if (preempt) begin
                  state_q    <= PH_SAVE;
                  cnt_q      <= CNT_LAST;
                  tgt_id_q   <= sel_id;
                  tgt_prio_q <= sel_prio;
               end
            end
            PH_REST: begin
               if (cnt_q == '0)
                  state_q <= (depth != '0) ? PH_RUN : PH_IDLE;
               else
                  cnt_q <= cnt_q - CW'(1);
            end
            default: state_q <= PH_IDLE;
         endcase
      end
   end

   assign exc_num   = 32'(tgt_id_q) + 32'(EXC_OFFSET);
   assign vec_addr  = tbl_base + (exc_num << 2);
   assign phase     = state_q;
   assign busy      = (state_q == PH_SAVE) || (state_q == PH_REST);
   assign hdl_start = stk_push;
   assign act_valid = (depth != '0);
   assign act_id    = top_id;

   // fetch is reached only at the end of a save or by a tail chain
   p_fetch_origin_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_FETCH) |->
         ($past(state_q) == PH_SAVE) || ($past(state_q) == PH_RUN && $past(hdl_done)));

   // a save entered from the run phase needs a strictly more urgent request
   p_preempt_urgent_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_SAVE && $past(state_q) == PH_RUN) |-> $past(sel_prio) < $past(top_prio));

   // a swapped target during a save is always more urgent
   p_late_more_urgent_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_SAVE && $past(state_q) == PH_SAVE && tgt_id_q != $past(tgt_id_q))
         |-> tgt_prio_q < $past(tgt_prio_q));

   // restore starts only from a finished handler
   p_restore_after_done_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_REST && $past(state_q) == PH_RUN) |-> $past(hdl_done));

   // the chosen line is pending and enabled
   p_pick_eligible_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> (pend_vec[sel_id] && irq_en[sel_id]));

   // run phase always has an active handler
   p_run_has_handler_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_RUN) |-> act_valid);

endmodule

// File: tb/tb_irq_nest_seq.sv
module tb_irq_nest_seq;

   localparam int N   = 8;
   localparam int PW  = 2;
   localparam int S   = 8;
   localparam int OFS = 16;
   localparam int IW  = 3;
   localparam logic [31:0] BASE = 32'h2000_0400;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    irq_req = '0;
   logic [N-1:0]    irq_en = '1;
   logic [N*PW-1:0] irq_prio = '0;
   logic            hdl_done = 1'b0;
   logic [2:0]      phase;
   logic            busy;
   logic            hdl_start;
   logic [31:0]     vec_addr;
   logic            act_valid;
   logic [IW-1:0]   act_id;

   int checks = 0;
   int errors = 0;
   int busy_run = 0;
   logic [31:0] exp_q[$];

   always #10 clk = ~clk;

   irq_nest_seq #(.NUM_LINES(N), .PRIO_W(PW), .STACK_CYCLES(S), .EXC_OFFSET(OFS)) dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en), .irq_prio(irq_prio),
      .tbl_base(BASE), .hdl_done(hdl_done), .phase(phase), .busy(busy),
      .hdl_start(hdl_start), .vec_addr(vec_addr), .act_valid(act_valid), .act_id(act_id)
   );

   function automatic logic [31:0] addr_of(input int line);
      return BASE + 32'(4 * (OFS + line));
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // monitor: every fetch pops the scoreboard, every busy run is measured
   always @(negedge clk) begin
      if (rst_n) begin
         if (hdl_start) begin
            if (exp_q.size() == 0)
               chk(1'b0, "R5 unexpected fetch", vec_addr, 32'h0);
            else begin
               logic [31:0] e;
               e = exp_q.pop_front();
               chk(vec_addr == e, "R3 R5 fetch order/address", vec_addr, e);
            end
         end
         if (busy)
            busy_run++;
         else if (busy_run > 0) begin
            chk(busy_run == S, "R4 R10 busy length", 32'(busy_run), 32'(S));
            busy_run = 0;
         end
      end
   end

   task automatic pulse(input int a, input int b);
      irq_req[a] = 1'b1;
      irq_req[b] = 1'b1;
      @(negedge clk);
      irq_req[a] = 1'b0;
      irq_req[b] = 1'b0;
   endtask

   task automatic wait_run(input int line, input string req);
      bit hit = 1'b0;
      for (int k = 0; k < 200 && !hit; k++) begin
         @(negedge clk);
         hit = (phase == 3'd3) && act_valid && (act_id == IW'(line));
      end
      chk(hit, req, 32'(act_id), 32'(line));
   endtask

   task automatic finish_handler(input logic [2:0] exp_ph, input string req);
      hdl_done = 1'b1;
      @(negedge clk);
      hdl_done = 1'b0;
      chk(phase == exp_ph, req, 32'(phase), 32'(exp_ph));
   endtask

   task automatic wait_idle(input string req);
      bit hit = 1'b0;
      for (int k = 0; k < 200 && !hit; k++) begin
         @(negedge clk);
         hit = (phase == 3'd0) && !act_valid;
      end
      chk(hit, req, 32'(phase), 32'd0);
   endtask

   task automatic set_prio(input int line, input int p);
      irq_prio[line*PW +: PW] = PW'(p);
   endtask

   initial begin
      for (int k = 0; k < 100000; k++) @(posedge clk);
      chk(1'b0, "watchdog expired", 32'h0, 32'h0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      set_prio(0, 0); set_prio(1, 2); set_prio(2, 1); set_prio(3, 2);
      set_prio(4, 2); set_prio(5, 1); set_prio(6, 3); set_prio(7, 0);
      irq_en[5] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(phase == 3'd0 && !busy && !hdl_start && !act_valid, "R1 reset state",
          {28'h0, phase, busy}, 32'h0);

      // R4 R5 simple entry and exit
      exp_q.push_back(addr_of(3));
      pulse(3, 3);
      wait_run(3, "R4 entry to run");
      finish_handler(3'd4, "R10 restore after done");
      wait_idle("R10 back to idle");

      // R2 disabled line latches pending but waits for enable
      pulse(5, 5);
      repeat (20) @(negedge clk);
      chk(phase == 3'd0, "R2 disabled line ignored", 32'(phase), 32'd0);
      exp_q.push_back(addr_of(5));
      irq_en[5] = 1'b1;
      wait_run(5, "R2 serviced after enable");
      finish_handler(3'd4, "R10 restore");
      wait_idle("R10 idle");

      // R6 preemption and R10 resume of the preempted handler
      exp_q.push_back(addr_of(1));
      pulse(1, 1);
      wait_run(1, "R6 first handler");
      exp_q.push_back(addr_of(2));
      pulse(2, 2);
      wait_run(2, "R6 preempting handler active");
      finish_handler(3'd4, "R10 restore after nested");
      wait_run(1, "R10 preempted handler resumes");
      finish_handler(3'd4, "R10 restore outer");
      wait_idle("R10 idle after nest");

      // R7 equal urgency waits, then R8 tail chain
      exp_q.push_back(addr_of(1));
      pulse(1, 1);
      wait_run(1, "R7 first handler");
      pulse(4, 4);
      begin
         int bad = 0;
         for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (phase != 3'd3 || act_id != IW'(1)) bad++;
         end
         chk(bad == 0, "R7 equal urgency holds", 32'(bad), 32'd0);
      end
      exp_q.push_back(addr_of(4));
      finish_handler(3'd2, "R8 tail chain to fetch");
      wait_run(4, "R8 chained handler");
      finish_handler(3'd4, "R10 restore");
      wait_idle("R10 idle");

      // R9 late arrival during save
      exp_q.push_back(addr_of(0));
      exp_q.push_back(addr_of(6));
      pulse(6, 6);
      while (phase != 3'd1) @(negedge clk);
      repeat (2) @(negedge clk);
      pulse(0, 0);
      wait_run(0, "R9 late arrival fetched first");
      finish_handler(3'd2, "R9 displaced line chained");
      wait_run(6, "R9 displaced line serviced");
      finish_handler(3'd4, "R10 restore");
      wait_idle("R10 idle");

      // R3 tie goes to lower line number
      exp_q.push_back(addr_of(2));
      exp_q.push_back(addr_of(5));
      pulse(5, 2);
      wait_run(2, "R3 tie lower line");
      finish_handler(3'd2, "R8 tail chain on tie");
      wait_run(5, "R3 second of tie");
      finish_handler(3'd4, "R10 restore");
      wait_idle("R10 idle");

      // R3 urgency beats line number
      exp_q.push_back(addr_of(7));
      exp_q.push_back(addr_of(6));
      pulse(6, 7);
      wait_run(7, "R3 urgent line first");
      finish_handler(3'd2, "R8 tail chain");
      wait_run(6, "R3 less urgent after");
      finish_handler(3'd4, "R10 restore");
      wait_idle("R10 idle");

      repeat (5) @(negedge clk);
      chk(exp_q.size() == 0, "R4 all expected fetches seen", 32'(exp_q.size()), 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule